// File: doc/BRIEF.md
# Serial Configuration Bit-Stream Reader

This block is the read side of a bit-wide configuration memory that feeds an FPGA while it loads at power-up. The loading device supplies the clock. Each clock edge on which the reader is selected moves an internal bit pointer one place through the array, and the bit under the pointer appears on a data output that can be switched off. The data output is given as a value plus a drive-enable flag, so a high-impedance pin can be observed without tristate modelling.

The reset/output-enable input has no fixed sense. A stored polarity bit decides which level of that input clears the pointer and which level lets the output drive, so a board needs no inverter in either wiring. When the whole array has been read, a cascade enable output goes low to select the next memory in a chain. It then runs a hold-and-follow sequence until the reader is reset again. A serial-enable input selects read mode. When serial-enable is low, the chip-enable no longer controls the reader. A synchronous preload port writes array rows and the polarity bit before reading starts.

Top module: `cfg_prom_reader`

## Requirements
- R1: With the pointer at 0, each clock edge at which `ser_en`=1, `ce_n`=0 and the reset/output-enable input is not at its reset level moves the pointer by one. The bit presented at pointer p is bit (p mod WORD_W) of row (p / WORD_W), where bit 0 is the least significant bit of the row. Reading therefore presents the stream row 0 bit 0 first, then row 0 bit 1, and so on.
- R2: `dout_en` is 1 exactly when `ser_en`=1, `ce_n`=0 and `rst_oe` is not at its reset level. Whenever `dout_en` is 0, `dout` is 0.
- R3: At a clock edge where `rst_oe` is at its reset level, the pointer returns to 0, the end-of-memory state clears and the cascade sequence returns to idle. The next read starts at bit 0.
- R4: When the polarity bit is 1, `rst_oe`=1 is the reset level. When it is 0, `rst_oe`=0 is the reset level. A write through `pl_pol_we` changes the polarity from the edge at which it is written.
- R5: While `ce_n`=1, the pointer holds its value.
- R6: The edge that moves past the last bit (pointer CAPACITY-1) sets the end-of-memory state. From then on `ceo_n`=0 and the pointer does not wrap. While in the end state, `dout` is 0 even when it is driven.
- R7: `ceo_n` stays 0 while `ce_n`=0 and the output is enabled. After a clock edge with `ce_n`=1, `ceo_n` follows `ce_n` from then on. After a reset edge (R3), `ceo_n` stays 1 until the whole array has been read again.
- R8: While `ser_en`=0, `ce_n` is ignored. The pointer holds its value and `dout_en` is 0.
- R9: While `rst_n`=0, the pointer, the end state and the cascade sequence clear, and the polarity bit takes the value POL_INIT. After reset, `ceo_n`=1.
- R10: A `pl_we` write at a clock edge replaces row `pl_row` with `pl_wdata`, and later reads of that row return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the loading device |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ser_en | input | 1 | Read mode when 1; the two-wire programming mode is assumed when 0 |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Reset/output-enable, with its sense set by the polarity bit |
| dout | output | 1 | Serial data value |
| dout_en | output | 1 | Data driver enable; 0 means high impedance |
| ceo_n | output | 1 | Cascade enable to the next memory, active low |
| pl_we | input | 1 | Preload row write strobe |
| pl_row | input | ROW_W | Preload row index |
| pl_wdata | input | WORD_W | Preload row data |
| pl_pol_we | input | 1 | Polarity bit write strobe |
| pl_pol | input | 1 | New polarity bit value |

## Verification
The bench builds the reader with CAPACITY 64 and WORD_W 8. This gives eight rows, so the end of memory is reached within 64 read clocks and the full cascade sequence (hold, follow, reset back to idle) can be exercised several times in a short run. With eight bits per row, the bench also checks the bit order inside a row and the step across a row boundary. Starting from POL_INIT 1 lets the bench switch the polarity to 0 during the run and see the reset level swap on the same input.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

   typedef enum logic [1:0] {
      CASC_IDLE   = 2'd0,
      CASC_HOLD   = 2'd1,
      CASC_FOLLOW = 2'd2
   } casc_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/prom_bit_store.sv
module prom_bit_store #(
   parameter int CAPACITY = 4096,
   parameter int WORD_W   = 8,
   localparam int ADDR_W  = $clog2(CAPACITY),
   localparam int SEL_W   = (WORD_W > 1) ? $clog2(WORD_W) : 1,
   localparam int ROWS    = CAPACITY / WORD_W,
   localparam int ROW_W   = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_ptr,
   output logic              rd_bit
);

   logic [WORD_W-1:0] mem [ROWS];
   logic [WORD_W-1:0] row_word;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_row] <= wr_data;
      end
   end

   generate
      if (WORD_W == 1) begin : g_bitwide
         assign row_word = mem[rd_ptr[ROW_W-1:0]];
         assign rd_bit   = row_word[0];
      end else begin : g_wordwide
         logic [SEL_W-1:0] sel;
         assign row_word = mem[rd_ptr[ADDR_W-1:SEL_W]];
         assign sel      = rd_ptr[SEL_W-1:0];
         assign rd_bit   = row_word[sel];
      end
   endgenerate

endmodule

// File: rtl/prom_bit_counter.sv
module prom_bit_counter #(
   parameter int CAPACITY = 4096,
   localparam int ADDR_W  = $clog2(CAPACITY)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr,
   output logic              at_end,
   output logic              last_step
);

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CAPACITY - 1);

   logic advance;

   assign advance   = step && !at_end;
   assign last_step = advance && (ptr == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         at_end <= 1'b0;
      end else if (clear) begin
         ptr    <= '0;
         at_end <= 1'b0;
      end else if (last_step) begin
         at_end <= 1'b1;
      end else if (advance) begin
         ptr    <= ptr + 1'b1;
      end
   end

endmodule

// File: rtl/prom_cascade_ctl.sv
module prom_cascade_ctl
   import prom_rd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic last_step,
   input  logic mode_rd,
   input  logic ce_n,
   output logic ceo_n
);

   casc_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (clear) begin
         st_d = CASC_IDLE;
      end else begin
         unique case (st_q)
            CASC_IDLE:   if (last_step)        st_d = CASC_HOLD;
            CASC_HOLD:   if (mode_rd && ce_n)  st_d = CASC_FOLLOW;
            CASC_FOLLOW: st_d = CASC_FOLLOW;
            default:     st_d = CASC_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= CASC_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   always_comb begin
      unique case (st_q)
         CASC_HOLD:   ceo_n = 1'b0;
         CASC_FOLLOW: ceo_n = ce_n;
         default:     ceo_n = 1'b1;
      endcase
   end

endmodule

// File: rtl/cfg_prom_reader.sv
module cfg_prom_reader
   import prom_rd_pkg::*;
#(
   parameter int   CAPACITY = 4096,
   parameter int   WORD_W   = 8,
   parameter logic POL_INIT = 1'b1,
   localparam int  ADDR_W   = $clog2(CAPACITY),
   localparam int  ROWS     = CAPACITY / WORD_W,
   localparam int  ROW_W    = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_en,
   input  logic              ce_n,
   input  logic              rst_oe,
   output logic              dout,
   output logic              dout_en,
   output logic              ceo_n,
   input  logic              pl_we,
   input  logic [ROW_W-1:0]  pl_row,
   input  logic [WORD_W-1:0] pl_wdata,
   input  logic              pl_pol_we,
   input  logic              pl_pol
);

   generate
      if (!is_pow2(CAPACITY)) begin : g_bad_cap
         $error("CAPACITY must be a power of two");
      end
      if (!is_pow2(WORD_W)) begin : g_bad_word
         $error("WORD_W must be a power of two");
      end
      if (CAPACITY < 2 * WORD_W) begin : g_bad_rows
         $error("CAPACITY must hold at least two rows");
      end
   endgenerate

   logic              pol_q;
   logic              reset_act;
   logic              step;
   logic [ADDR_W-1:0] rd_ptr;
   logic              end_q;
   logic              last_step;
   logic              rd_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q <= POL_INIT;
      end else if (pl_pol_we) begin
         pol_q <= pl_pol;
      end
   end

   assign reset_act = (rst_oe == pol_q);
   assign step      = ser_en && !ce_n && !reset_act;

   prom_bit_counter #(
      .CAPACITY (CAPACITY)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (reset_act),
      .step      (step),
      .ptr       (rd_ptr),
      .at_end    (end_q),
      .last_step (last_step)
   );

   prom_bit_store #(
      .CAPACITY (CAPACITY),
      .WORD_W   (WORD_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (pl_we),
      .wr_row  (pl_row),
      .wr_data (pl_wdata),
      .rd_ptr  (rd_ptr),
      .rd_bit  (rd_bit)
   );

   prom_cascade_ctl u_casc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (reset_act),
      .last_step (last_step),
      .mode_rd   (ser_en),
      .ce_n      (ce_n),
      .ceo_n     (ceo_n)
   );

   assign dout_en = ser_en && !ce_n && !reset_act;
   assign dout    = dout_en && !end_q && rd_bit;

endmodule

// File: rtl/prom_reader_chk.sv
module prom_reader_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ser_en,
   input logic              ce_n,
   input logic              dout,
   input logic              dout_en,
   input logic              ceo_n,
   input logic [ADDR_W-1:0] ptr,
   input logic              done,
   input logic              reset_act
);

   // R2
   no_drive_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || !ser_en) |-> (!dout_en && !dout));

   // R3
   reset_clears_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_act |=> (ptr == '0 && !done && ceo_n));

   // R5
   hold_when_ce_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && !reset_act) |=> (ptr == $past(ptr) && done == $past(done)));

   // R8
   hold_in_prog_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_en && !reset_act) |=> (ptr == $past(ptr)));

   // R6
   end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !reset_act) |=> (done && ptr == $past(ptr)));

   // R6
   ceo_low_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !ceo_n);

   // R7
   ceo_low_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ceo_n |-> done);

endmodule

bind cfg_prom_reader prom_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ser_en    (ser_en),
   .ce_n      (ce_n),
   .dout      (dout),
   .dout_en   (dout_en),
   .ceo_n     (ceo_n),
   .ptr       (rd_ptr),
   .done      (end_q),
   .reset_act (reset_act)
);

// File: tb/sim_cfg_prom_reader.sv
`timescale 1ns/1ps
module sim_cfg_prom_reader;

   localparam int CAP   = 64;
   localparam int WW    = 8;
   localparam int NROWS = CAP / WW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ser_en, ce_n, rst_oe;
   logic          dout, dout_en, ceo_n;
   logic          pl_we, pl_pol_we, pl_pol;
   logic [2:0]    pl_row;
   logic [WW-1:0] pl_wdata;

   int   n_chk  = 0;
   int   n_bad  = 0;
   bit   closed = 1'b0;
   bit   exp_q[$];
   logic [WW-1:0] model [NROWS];
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   cfg_prom_reader #(.CAPACITY(CAP), .WORD_W(WW), .POL_INIT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ce_n), .rst_oe(rst_oe),
      .dout(dout), .dout_en(dout_en), .ceo_n(ceo_n),
      .pl_we(pl_we), .pl_row(pl_row), .pl_wdata(pl_wdata),
      .pl_pol_we(pl_pol_we), .pl_pol(pl_pol)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!closed) begin
         closed = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: pops one expected bit per sampled cycle
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         chk(dout_en === 1'b1 && dout === e, cur_req, {30'd0, dout_en, dout}, {30'd0, 1'b1, e});
      end
   end

   // driver: queue expected stream bits, select the reader, consume the last one
   task automatic read_bits(input int start, input int n, input string req);
      cur_req = req;
      @(posedge clk); #1;
      for (int k = start; k < start + n; k++) begin
         exp_q.push_back(model[k / WW][k % WW]);
      end
      ce_n = 1'b0;
      wait (exp_q.size() == 0);
      @(posedge clk); #1;
      ce_n = 1'b1;
   endtask

   task automatic load_row(input int r, input logic [WW-1:0] d);
      @(posedge clk); #1;
      pl_we = 1'b1; pl_row = 3'(r); pl_wdata = d;
      @(posedge clk); #1;
      pl_we = 1'b0;
      model[r] = d;
   endtask

   task automatic set_pol(input logic p);
      @(posedge clk); #1;
      pl_pol_we = 1'b1; pl_pol = p;
      @(posedge clk); #1;
      pl_pol_we = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; ser_en = 1'b1; ce_n = 1'b1; rst_oe = 1'b0;
      pl_we = 1'b0; pl_row = '0; pl_wdata = '0; pl_pol_we = 1'b0; pl_pol = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int r = 0; r < NROWS; r++) load_row(r, WW'((r * 53 + 29) ^ (r << 4)));

      // R9: state after reset
      @(negedge clk);
      chk(ceo_n === 1'b1, "R9", ceo_n, 1);
      chk(dout_en === 1'b0, "R9", dout_en, 0);

      // R1 stream, then R5 hold with ce_n high
      read_bits(0, 10, "R1");
      repeat (3) begin
         @(negedge clk);
         chk(dout_en === 1'b0 && dout === 1'b0, "R2", {dout_en, dout}, 0);
      end
      read_bits(10, 5, "R5");

      // R8: programming mode ignores ce_n
      ser_en = 1'b0; ce_n = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk(dout_en === 1'b0, "R8", dout_en, 0);
      end
      #1 ce_n = 1'b1; ser_en = 1'b1;
      read_bits(15, CAP - 15, "R1");

      // R6: end of memory reached at the last consuming edge
      chk(ceo_n === 1'b0, "R6", ceo_n, 0);
      ce_n = 1'b0;
      @(negedge clk);
      chk(dout_en === 1'b1 && dout === 1'b0, "R6", {dout_en, dout}, 2);
      repeat (3) @(posedge clk);
      #1 chk(ceo_n === 1'b0, "R7", ceo_n, 0);
      // R7: follow phase
      ce_n = 1'b1;
      @(posedge clk); #1;
      chk(ceo_n === 1'b1, "R7", ceo_n, 1);
      ce_n = 1'b0;
      #1 chk(ceo_n === 1'b0, "R7", ceo_n, 0);

      // R3: reset level clears the sequence
      rst_oe = 1'b1;
      @(negedge clk);
      chk(dout_en === 1'b0, "R2", dout_en, 0);
      @(posedge clk); #1;
      chk(ceo_n === 1'b1, "R3", ceo_n, 1);
      ce_n = 1'b1;
      #1 rst_oe = 1'b0;
      @(posedge clk); #1;
      chk(ceo_n === 1'b1, "R7", ceo_n, 1);

      // R10: rewritten row seen on the restarted stream (R3 restart at 0)
      load_row(0, 8'h6C);
      read_bits(0, 8, "R10");
      read_bits(8, 3, "R3");

      // R4: polarity 0 makes rst_oe low the reset level
      set_pol(1'b0);
      ce_n = 1'b0;
      @(negedge clk);
      chk(dout_en === 1'b0, "R4", dout_en, 0);
      @(posedge clk); #1;
      ce_n = 1'b1;
      rst_oe = 1'b1;
      read_bits(0, 4, "R4");

      finish_run();
   end

endmodule